// File: doc/BRIEF.md
# QPP Interleaver Address Generator

This block produces the addresses of a quadratic permutation polynomial interleaver for one code block of length K. It emits one address per clock. The target mapping is pi(i) = (f1·i + f2·i²) mod K. The block does not evaluate the polynomial directly. It keeps a running address and a running auxiliary term and steps both with modular additions. Each modular addition is an add, a compare against K and a conditional subtract. No multiplier is used anywhere. One step of the address update passes through four adders and two multiplexers.

A start pulse captures three values: the block length, the two polynomial coefficients and a starting index s. The block then precomputes two constants, (f1+f2) mod K and (2·f2) mod K. If s is nonzero, the block steps the recurrence s times from index zero with the output held invalid. This lets one engine of a sub-block parallel decoder begin part way through the permutation. The block then streams exactly K addresses, for indices s, s+1, …, wrapping modulo K.

The addresses leave on a valid/ready stream. The address is transferred on a clock edge where out_valid and out_ready are both high. While out_ready is low, the address and the last flag are held unchanged. The caller must supply 40 ≤ K < 2^ADDR_W with f1, f2 and s all below K.

Top module: `qpp_addr_gen`

## Requirements
- R1: While rst_n is low, and afterwards until a start is sampled, out_valid and busy are 0.
- R2: With first_idx = 0, the j-th transferred address (j = 0…K−1) equals (f1·j + f2·j²) mod K.
- R3: With first_idx = s > 0, the j-th transferred address equals pi((s+j) mod K), where pi is the polynomial of R2.
- R4: Count the rising edge that samples start as edge 1. out_valid first goes high right after edge s+2, and stays low until then.
- R5: Exactly K addresses are transferred per block. out_last is 1 on the final one only. In the cycle after that transfer, out_valid and busy are 0.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1, and out_addr and out_last keep their values into the next cycle.
- R7: A start pulse while busy is 1 is ignored: the running block continues unchanged to its K-th address.
- R8: Every valid address is below the captured K.
- R9: blk_len, coef_a, coef_b and first_idx are sampled only on the edge that accepts start; changing them later has no effect on the block.
- R10: busy is 1 from the edge that accepts start until the edge of the final transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; accepted only when idle |
| blk_len | input | ADDR_W | Block length K |
| coef_a | input | ADDR_W | Linear coefficient f1, below K |
| coef_b | input | ADDR_W | Quadratic coefficient f2, below K |
| first_idx | input | ADDR_W | Starting index s, below K |
| busy | output | 1 | A block is in progress |
| out_valid | output | 1 | out_addr holds an address |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | ADDR_W | Interleaved address |
| out_last | output | 1 | Marks the K-th address of the block |

## Verification
The bench walks several valid coefficient sets, from the shortest block length to the longest, and compares every transferred address with a direct evaluation of the polynomial. Zero starting indices check the plain ordering. Nonzero ones, including s = K−1, check the seek phase and the wrap of the index past K. A pseudo-random ready pattern separates the hold-under-back-pressure behaviour from the always-ready case. One vector drives the inputs to other values mid-block, and another raises start mid-block; together they show that inputs are captured only on the accepted start and that a second start is ignored. A directed reset during a block confirms that the outputs return to idle.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_SEEK = 2'd2,
    ST_EMIT = 2'd3
  } qpp_state_e;
endpackage

// File: rtl/qpp_modadd.sv
// (a + b) mod m for a, b < m: add, then subtract m when the difference is non-negative.
module qpp_modadd #(
  parameter int W = 13
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic [W-1:0] y
);
  logic [W:0]   sum;
  logic [W+1:0] diff;

  assign sum  = {1'b0, a} + {1'b0, b};
  assign diff = {1'b0, sum} - {2'b00, m};
  assign y    = diff[W+1] ? sum[W-1:0] : diff[W-1:0];
endmodule

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] first_idx,
  input  logic [W-1:0] k_q,
  input  logic         out_ready,
  output logic         cap,
  output logic         clr,
  output logic         step,
  output logic         out_valid,
  output logic         out_last,
  output logic         busy
);
  qpp_state_e   state, state_nx;
  logic [W-1:0] s_q;
  logic [W-1:0] seek_cnt;
  logic [W-1:0] emit_cnt;
  logic         seek_done;

  assign seek_done = (seek_cnt == s_q - W'(1));
  assign busy      = (state != ST_IDLE);
  assign out_valid = (state == ST_EMIT);
  assign out_last  = out_valid && (emit_cnt == k_q - W'(1));
  assign cap       = (state == ST_IDLE) && start;
  assign clr       = (state == ST_PREP);

  always_comb begin
    state_nx = state;
    step     = 1'b0;
    case (state)
      ST_IDLE: if (start) state_nx = ST_PREP;
      ST_PREP: state_nx = (s_q == '0) ? ST_EMIT : ST_SEEK;
      ST_SEEK: begin
        step = 1'b1;
        if (seek_done) state_nx = ST_EMIT;
      end
      ST_EMIT: begin
        step = out_ready;
        if (out_ready && out_last) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      s_q      <= '0;
      seek_cnt <= '0;
      emit_cnt <= '0;
    end else begin
      state <= state_nx;
      if (cap) s_q <= first_idx;
      if (clr) begin
        seek_cnt <= '0;
        emit_cnt <= '0;
      end else begin
        if (state == ST_SEEK) seek_cnt <= seek_cnt + W'(1);
        if (state == ST_EMIT && out_ready) emit_cnt <= emit_cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] blk_len,
  input  logic [ADDR_W-1:0] coef_a,
  input  logic [ADDR_W-1:0] coef_b,
  input  logic [ADDR_W-1:0] first_idx,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_last
);
  localparam int W = ADDR_W;

  logic [W-1:0] k_q, f1_q, f2_q, c1_q, c2_q, pi_q, lam_q;
  logic [W-1:0] c1_d, c2_d, pi_mid, pi_d, lam_d;
  logic         cap, clr, step;

  qpp_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx),
    .k_q(k_q), .out_ready(out_ready), .cap(cap), .clr(clr), .step(step),
    .out_valid(out_valid), .out_last(out_last), .busy(busy)
  );

  // Constants, evaluated once in the preparation cycle
  qpp_modadd #(.W(W)) u_c1  (.a(f1_q),   .b(f2_q),  .m(k_q), .y(c1_d));
  qpp_modadd #(.W(W)) u_c2  (.a(f2_q),   .b(f2_q),  .m(k_q), .y(c2_d));
  // Per-step recurrence: two chained modular adds for the address, one for lambda
  qpp_modadd #(.W(W)) u_pa  (.a(pi_q),   .b(c1_q),  .m(k_q), .y(pi_mid));
  qpp_modadd #(.W(W)) u_pb  (.a(pi_mid), .b(lam_q), .m(k_q), .y(pi_d));
  qpp_modadd #(.W(W)) u_lam (.a(lam_q),  .b(c2_q),  .m(k_q), .y(lam_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q   <= '0;
      f1_q  <= '0;
      f2_q  <= '0;
      c1_q  <= '0;
      c2_q  <= '0;
      pi_q  <= '0;
      lam_q <= '0;
    end else begin
      if (cap) begin
        k_q  <= blk_len;
        f1_q <= coef_a;
        f2_q <= coef_b;
      end
      if (clr) begin
        c1_q  <= c1_d;
        c2_q  <= c2_d;
        pi_q  <= '0;
        lam_q <= '0;
      end else if (step) begin
        pi_q  <= pi_d;
        lam_q <= lam_d;
      end
    end
  end

  assign out_addr = pi_q;
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_last,
  input logic [ADDR_W-1:0] k_q
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_last));

  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr < k_q);

  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && !busy);

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(out_valid && out_ready && out_last) |=> busy);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_last(out_last), .k_q(k_q)
);

// File: tb/tb_qpp_addr_gen.sv
`timescale 1ns/1ps
module tb_qpp_addr_gen;
  localparam int W  = 13;
  localparam int NV = 9;
  // columns: K, f1, f2, start index, ready mode, garble inputs, extra start
  localparam int VK [NV] = '{40, 40, 48, 56, 64, 104, 512, 1024, 6144};
  localparam int VF1[NV] = '{3, 3, 7, 19, 7, 7, 31, 31, 263};
  localparam int VF2[NV] = '{10, 10, 12, 42, 16, 26, 64, 64, 480};
  localparam int VS [NV] = '{0, 39, 0, 17, 5, 50, 0, 500, 1000};
  localparam int VM [NV] = '{0, 1, 1, 0, 1, 1, 0, 1, 0};
  localparam int VG [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0};
  localparam int VR [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 0};

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [W-1:0] blk_len = '0, coef_a = '0, coef_b = '0, first_idx = '0;
  logic busy, out_valid, out_last;
  logic out_ready = 0;
  logic [W-1:0] out_addr;
  int checks = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  qpp_addr_gen #(.ADDR_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .coef_a(coef_a), .coef_b(coef_b), .first_idx(first_idx), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_last(out_last)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_block(input int k, input int f1, input int f2, input int s,
                           input int mode, input int garb, input int again);
    int lat, got;
    logic stall;
    logic [W-1:0] p_addr;
    logic p_last, rdy;
    longint jj, exp;
    blk_len = W'(k); coef_a = W'(f1); coef_b = W'(f2); first_idx = W'(s);
    start = 1;
    @(negedge clk);
    start = 0;
    if (garb != 0) begin  // R9: later input changes must not matter
      blk_len = W'(k - 7); coef_a = W'(1); coef_b = W'(2); first_idx = W'(3);
    end
    lat = 1;
    check(busy == 1'b1, "R10 busy after start", longint'(busy), 1);
    while (!out_valid && lat < s + 10) begin
      @(negedge clk);
      lat++;
    end
    check(lat == s + 2, "R4 first valid latency", lat, s + 2);
    got = 0; stall = 0; p_addr = '0; p_last = 0;
    while (out_valid && got < k + 2) begin
      if (stall)
        check(out_addr == p_addr && out_last == p_last, "R6 hold under back-pressure",
              longint'(out_addr), longint'(p_addr));
      check(out_addr < W'(k), "R8 address range", longint'(out_addr), k - 1);
      rdy = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
      out_ready = rdy;
      if (rdy) begin
        jj  = longint'((s + got) % k);
        exp = (longint'(f1) * jj + longint'(f2) * jj * jj) % longint'(k);
        if (s == 0)
          check(longint'(out_addr) == exp, (garb != 0) ? "R2 R9 address" : "R2 address",
                longint'(out_addr), exp);
        else
          check(longint'(out_addr) == exp, "R3 address", longint'(out_addr), exp);
        check(out_last == (got == k - 1), "R5 last flag", longint'(out_last),
              longint'(got == k - 1));
        got++;
      end
      stall = !rdy; p_addr = out_addr; p_last = out_last;
      if (again != 0 && got == 3) begin  // R7: start while busy
        start = 1; blk_len = W'(40); coef_a = W'(3); coef_b = W'(10); first_idx = W'(0);
      end else start = 0;
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    start = 0;
    out_ready = 0;
    check(got == k, (again != 0) ? "R5 R7 address count" : "R5 address count", got, k);
    check(!out_valid && !busy, "R5 R10 idle after last", longint'({out_valid, busy}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !busy, "R1 during reset", longint'({out_valid, busy}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!out_valid && !busy, "R1 idle after reset", longint'({out_valid, busy}), 0);

    for (int v = 0; v < NV; v++) begin
      run_block(VK[v], VF1[v], VF2[v], VS[v], VM[v], VG[v], VR[v]);
      repeat (2) @(negedge clk);
    end

    // Directed: reset in the middle of a block
    blk_len = W'(64); coef_a = W'(7); coef_b = W'(16); first_idx = W'(0);
    start = 1;
    @(negedge clk);
    start = 0;
    out_ready = 1;
    repeat (10) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(!out_valid && !busy, "R1 reset mid-block", longint'({out_valid, busy}), 0);
    rst_n = 1;
    out_ready = 0;
    repeat (2) @(negedge clk);
    check(!out_valid && !busy, "R1 idle after mid-block reset", longint'({out_valid, busy}), 0);

    // Directed: a fresh block after the reset still starts from index zero
    run_block(40, 3, 10, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule